// File: doc/BRIEF.md
# Dual-Submodule Short-Address DMA Channel

This block is one DMA channel that holds two independent submodules, A and B. Each submodule moves data between a 24-bit memory address and a fixed I/O address. The I/O address is built from an 8-bit register with all upper bits forced to one. Software writes each submodule's memory address, I/O address, transfer count and control byte through a small register port, then sets the enable bit. After that, every selected trigger event moves one byte or one word: a read followed by a write on a request/acknowledge memory master port.

Two control bits pick the operating mode. Sequential mode walks the memory address and stops when the count is used up. Idle mode keeps the memory address fixed and also stops when the count is used up. Repeat mode walks an 8-bit count and then reloads both the count and the memory address, so it runs without end. If submodule A's trigger field has both bits 2 and 1 set, the channel is configured for full address operation. This block does not implement that mode, so it then starts no transfers at all.

A single engine serves both submodules through three states: IDLE, READ and WRITE.
- IDLE goes to READ when a submodule has a pending transfer. A wins over B.
- READ goes to WRITE on acknowledge. The read data is captured.
- WRITE goes back to IDLE on acknowledge. The finished submodule's count and address are updated.

Top module: `dual_short_dma`

## Requirements
- R1: Register fields, selected by `reg_field`, are: 0 memory address (24 bits), 1 I/O address (8 bits), 2 count (16 bits), 3 control (8 bits), 4 enable (bit 7). Reading the I/O address field returns 0xFF in bits 15:8 above the written byte.
- R2: Each transfer is one read request followed by one write request. A request stays asserted with a stable address until acknowledged. The write data equals the read data.
- R3: The I/O side address is 0xFFFF00 OR the I/O address register, and it never moves. With control bit 4 = 1 the block reads the I/O side and writes the memory side. With bit 4 = 0 it reads the memory side and writes the I/O side.
- R4: In sequential mode the memory address moves by 1 (control bit 7 = 0, byte) or by 2 (bit 7 = 1, word) per transfer. It increments when control bit 6 = 0 and decrements when bit 6 = 1.
- R5: Sequential mode (control bit 5 = 0) performs exactly `count` transfers and then clears the enable bit. It raises its `irq_end` bit only when control bit 3 = 1.
- R6: Idle mode (bits 5 and 3 both 1) uses one unchanging memory address for every transfer. At the end it clears the enable bit and raises `irq_end`.
- R7: Repeat mode (bit 5 = 1, bit 3 = 0) counts only count bits 7:0, where 0 means 256. At the end it reloads the count and the memory address, stays enabled and raises no interrupt.
- R8: Control bits 2:0 select the trigger. Codes 0 to 3 are `tmr_evt[0..3]`, 4 is `tx_empty` and 5 is `rx_full`. A pulse on any other source starts nothing.
- R9: For submodule B, code 6 starts one transfer per falling edge of `dreq_n`. Code 7 keeps starting transfers while `dreq_n` is low.
- R10: While submodule A's control bits 2:1 are both 1, neither submodule starts a transfer.
- R11: When both submodules become pending in the same cycle, A's transfer is performed before B's.
- R12: `irq_end` stays high until the enable field of that submodule is written again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_unit | input | 1 | Submodule select: 0 = A, 1 = B |
| reg_field | input | 3 | Register field select |
| reg_wdata | input | 24 | Register write data |
| reg_rdata | output | 24 | Read data of the selected field |
| tmr_evt | input | 4 | Timer compare event pulses |
| tx_empty | input | 1 | Serial transmit-empty pulse |
| rx_full | input | 1 | Serial receive-full pulse |
| dreq_n | input | 1 | External transfer request, active low |
| m_req | output | 1 | Memory request |
| m_we | output | 1 | 1 = write phase, 0 = read phase |
| m_word | output | 1 | 1 = 16-bit transfer, 0 = byte |
| m_addr | output | 24 | Memory address |
| m_wdata | output | 16 | Write data |
| m_ack | input | 1 | Memory acknowledge |
| m_rdata | input | 16 | Read data, valid with acknowledge |
| irq_end | output | 2 | Transfer-end interrupts, bit 0 = A, bit 1 = B |

## Verification
Two cases are hard to reach from the ports.

The first is the moment when both submodules become pending in one cycle. The stimulus creates it by giving A and B the same timer source and firing that source once. The expected order is then A's addresses first, then B's.

The second is the repeat wrap with a zero low count byte, which needs 256 triggered transfers before the reload is visible. A directed run performs 257 transfers and checks that the last one restarts at the programmed memory address.

The random runs draw the control byte, the addresses and a short count. Each transfer's addresses are predicted from the mode bits.

// File: rtl/dsd_pkg.sv
`timescale 1ns/1ps
package dsd_pkg;
    typedef enum logic [2:0] {
        FLD_MAR = 3'd0,
        FLD_IOA = 3'd1,
        FLD_CNT = 3'd2,
        FLD_CTL = 3'd3,
        FLD_ENA = 3'd4
    } fld_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } eng_st_t;

    localparam int unsigned N_EVT = 8;
endpackage

// File: rtl/dsd_unit.sv
`timescale 1ns/1ps
module dsd_unit
    import dsd_pkg::*;
#(
    parameter int UNIT_ID = 0,
    parameter int AW      = 24,
    parameter int CW      = 16,
    parameter int IOW     = 8,
    parameter int RPTW    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_field,
    input  logic [AW-1:0]     wr_data,
    input  logic [2:0]        rd_field,
    input  logic [N_EVT-1:0]  events,
    input  logic              halt,
    input  logic              step_done,
    output logic              xfer_req,
    output logic              dir_o,
    output logic              word_o,
    output logic              halt_o,
    output logic              irq_o,
    output logic [AW-1:0]     ptr_o,
    output logic [IOW-1:0]    io_o,
    output logic [AW-1:0]     rd_data
);
    localparam int RW = CW + 1;

    logic [7:0]     ctrl;
    logic [AW-1:0]  mar, ptr, step, ptr_nx;
    logic [IOW-1:0] ioa;
    logic [CW-1:0]  cnt;
    logic [RW-1:0]  left, full_load, rep_load;
    logic           en, pend, irq, hit;
    logic           idle_m, rep_m, last;

    assign idle_m    = ctrl[5] & ctrl[3];
    assign rep_m     = ctrl[5] & ~ctrl[3];
    assign full_load = (cnt == '0) ? (RW'(1) << CW) : RW'(cnt);
    assign rep_load  = (cnt[RPTW-1:0] == '0) ? (RW'(1) << RPTW) : RW'(cnt[RPTW-1:0]);
    assign step      = ctrl[7] ? AW'(2) : AW'(1);
    assign ptr_nx    = idle_m ? ptr : (ctrl[6] ? ptr - step : ptr + step);
    assign last      = (left == RW'(1));

    generate
        if (UNIT_ID == 0) begin : g_side_a
            assign hit    = (ctrl[2:1] != 2'b11) & events[ctrl[2:0]];
            assign halt_o = (ctrl[2:1] == 2'b11);
        end else begin : g_side_b
            assign hit    = events[ctrl[2:0]];
            assign halt_o = 1'b0;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl <= '0; mar <= '0; ptr <= '0; ioa <= '0; cnt <= '0;
            left <= '0; en <= 1'b0; pend <= 1'b0; irq <= 1'b0;
        end else if (wr_en) begin
            unique case (fld_t'(wr_field))
                FLD_MAR: mar  <= wr_data;
                FLD_IOA: ioa  <= wr_data[IOW-1:0];
                FLD_CNT: cnt  <= wr_data[CW-1:0];
                FLD_CTL: ctrl <= wr_data[7:0];
                FLD_ENA: begin
                    en   <= wr_data[7];
                    irq  <= 1'b0;
                    pend <= 1'b0;
                    left <= rep_m ? rep_load : full_load;
                    ptr  <= mar;
                end
                default: ;
            endcase
        end else begin
            if (step_done) begin
                if (!last) begin
                    left <= left - RW'(1);
                    ptr  <= ptr_nx;
                end else if (rep_m) begin
                    left <= rep_load;
                    ptr  <= mar;
                end else begin
                    en  <= 1'b0;
                    irq <= ctrl[3];
                end
            end
            if (hit && en && !halt) pend <= 1'b1;
            else if (step_done)     pend <= 1'b0;
        end
    end

    always_comb begin
        unique case (fld_t'(rd_field))
            FLD_MAR: rd_data = mar;
            FLD_IOA: rd_data = AW'({8'hFF, ioa});
            FLD_CNT: rd_data = AW'(cnt);
            FLD_CTL: rd_data = AW'(ctrl);
            FLD_ENA: rd_data = AW'({en, 7'b0});
            default: rd_data = '0;
        endcase
    end

    assign xfer_req = pend & en & ~halt;
    assign dir_o    = ctrl[4];
    assign word_o   = ctrl[7];
    assign irq_o    = irq;
    assign ptr_o    = ptr;
    assign io_o     = ioa;
endmodule

// File: rtl/dsd_engine.sv
`timescale 1ns/1ps
module dsd_engine
    import dsd_pkg::*;
#(
    parameter int AW  = 24,
    parameter int DW  = 16,
    parameter int IOW = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          req,
    input  logic [1:0]          dir,
    input  logic [1:0]          word,
    input  logic [1:0][AW-1:0]  ptr,
    input  logic [1:0][IOW-1:0] io,
    input  logic                m_ack,
    input  logic [DW-1:0]       m_rdata,
    output logic                m_req,
    output logic                m_we,
    output logic                m_word,
    output logic [AW-1:0]       m_addr,
    output logic [DW-1:0]       m_wdata,
    output logic [1:0]          done,
    output logic                busy
);
    eng_st_t       st, st_nx;
    logic          cur;
    logic [DW-1:0] data;
    logic [AW-1:0] io_full;

    assign io_full = {{(AW-IOW){1'b1}}, io[cur]};

    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE:  if (req != 2'b00) st_nx = ST_READ;
            ST_READ:  if (m_ack)        st_nx = ST_WRITE;
            ST_WRITE: if (m_ack)        st_nx = ST_IDLE;
            default:                    st_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur  <= 1'b0;
            data <= '0;
        end else begin
            if (st == ST_IDLE && req != 2'b00) cur  <= ~req[0];
            if (st == ST_READ && m_ack)        data <= m_rdata;
        end
    end

    always_comb begin
        m_req   = 1'b0;
        m_we    = 1'b0;
        m_addr  = '0;
        done    = 2'b00;
        unique case (st)
            ST_IDLE: ;
            ST_READ: begin
                m_req  = 1'b1;
                m_addr = dir[cur] ? io_full : ptr[cur];
            end
            ST_WRITE: begin
                m_req  = 1'b1;
                m_we   = 1'b1;
                m_addr = dir[cur] ? ptr[cur] : io_full;
                if (m_ack) done[cur] = 1'b1;
            end
            default: ;
        endcase
        m_word  = word[cur];
        m_wdata = data;
        busy    = (st != ST_IDLE);
    end
endmodule

// File: rtl/dual_short_dma.sv
`timescale 1ns/1ps
module dual_short_dma
    import dsd_pkg::*;
#(
    parameter int AW   = 24,
    parameter int CW   = 16,
    parameter int IOW  = 8,
    parameter int DW   = 16,
    parameter int RPTW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic          reg_unit,
    input  logic [2:0]    reg_field,
    input  logic [AW-1:0] reg_wdata,
    output logic [AW-1:0] reg_rdata,
    input  logic [3:0]    tmr_evt,
    input  logic          tx_empty,
    input  logic          rx_full,
    input  logic          dreq_n,
    output logic          m_req,
    output logic          m_we,
    output logic          m_word,
    output logic [AW-1:0] m_addr,
    output logic [DW-1:0] m_wdata,
    input  logic          m_ack,
    input  logic [DW-1:0] m_rdata,
    output logic [1:0]    irq_end
);
    logic                dreq_q, halt_all, eng_busy;
    logic [N_EVT-1:0]    events;
    logic [1:0]          unit_req, unit_dir, unit_word, unit_halt, eng_done;
    logic [1:0][AW-1:0]  unit_ptr, unit_rd;
    logic [1:0][IOW-1:0] unit_io;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dreq_q <= 1'b1;
        else        dreq_q <= dreq_n;
    end

    assign events   = {~dreq_n, dreq_q & ~dreq_n, rx_full, tx_empty, tmr_evt};
    assign halt_all = |unit_halt;

    for (genvar u = 0; u < 2; u++) begin : g_unit
        dsd_unit #(.UNIT_ID(u), .AW(AW), .CW(CW), .IOW(IOW), .RPTW(RPTW)) u_unit (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (reg_we && (reg_unit == 1'(u))),
            .wr_field (reg_field),
            .wr_data  (reg_wdata),
            .rd_field (reg_field),
            .events   (events),
            .halt     (halt_all),
            .step_done(eng_done[u]),
            .xfer_req (unit_req[u]),
            .dir_o    (unit_dir[u]),
            .word_o   (unit_word[u]),
            .halt_o   (unit_halt[u]),
            .irq_o    (irq_end[u]),
            .ptr_o    (unit_ptr[u]),
            .io_o     (unit_io[u]),
            .rd_data  (unit_rd[u])
        );
    end

    assign reg_rdata = unit_rd[reg_unit];

    dsd_engine #(.AW(AW), .DW(DW), .IOW(IOW)) u_eng (
        .clk    (clk),
        .rst_n  (rst_n),
        .req    (unit_req),
        .dir    (unit_dir),
        .word   (unit_word),
        .ptr    (unit_ptr),
        .io     (unit_io),
        .m_ack  (m_ack),
        .m_rdata(m_rdata),
        .m_req  (m_req),
        .m_we   (m_we),
        .m_word (m_word),
        .m_addr (m_addr),
        .m_wdata(m_wdata),
        .done   (eng_done),
        .busy   (eng_busy)
    );
endmodule

// File: rtl/dsd_checker.sv
`timescale 1ns/1ps
module dsd_checker #(
    parameter int AW = 24
) (
    input logic          clk,
    input logic          rst_n,
    input logic          m_req,
    input logic          m_we,
    input logic          m_ack,
    input logic [AW-1:0] m_addr,
    input logic [1:0]    eng_done,
    input logic          halt_all,
    input logic          eng_busy
);
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        m_req && !m_ack |=> m_req && $stable(m_addr) && $stable(m_we)); // R2
    AST_READ_THEN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        m_req && m_ack && !m_we |=> m_req && m_we); // R2
    AST_WRITE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        m_req && m_ack && m_we |=> !m_req); // R2
    AST_ONE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(eng_done)); // R11
    AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        halt_all && !eng_busy |=> !m_req); // R10
endmodule

bind dual_short_dma dsd_checker #(.AW(AW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .m_req   (m_req),
    .m_we    (m_we),
    .m_ack   (m_ack),
    .m_addr  (m_addr),
    .eng_done(eng_done),
    .halt_all(halt_all),
    .eng_busy(eng_busy)
);

// File: tb/sim_dual_short_dma.sv
`timescale 1ns/1ps
module sim_dual_short_dma;
    import dsd_pkg::*;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        reg_we = 1'b0, reg_unit = 1'b0;
    logic [2:0]  reg_field = '0;
    logic [23:0] reg_wdata = '0, reg_rdata;
    logic [3:0]  tmr_evt = '0;
    logic        tx_empty = 1'b0, rx_full = 1'b0, dreq_n = 1'b1;
    logic        m_req, m_we, m_word, m_ack = 1'b0;
    logic [23:0] m_addr;
    logic [15:0] m_wdata, m_rdata = '0;
    logic [1:0]  irq_end;

    int checks = 0, errors = 0, seen = 0;
    logic [23:0] q_rd[$], q_wr[$];
    logic [23:0] last_rd = '0;

    dual_short_dma u0 (.*);

    always #2.5 clk = ~clk;

    function automatic logic [15:0] dat_of(logic [23:0] a);
        return a[15:0] ^ 16'hA5C3;
    endfunction

    function automatic logic [23:0] mem_at(logic [7:0] c, logic [23:0] mar, logic [15:0] cnt, int k);
        int pos, len, stp;
        stp = c[7] ? 2 : 1;
        if (c[5] && c[3]) pos = 0;
        else if (c[5]) begin
            len = (cnt[7:0] == 0) ? 256 : int'(cnt[7:0]);
            pos = k % len;
        end else pos = k;
        return c[6] ? mar - 24'(pos * stp) : mar + 24'(pos * stp);
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // memory model: random latency, records every transfer
    initial begin
        int lat = 0;
        forever begin
            @(negedge clk);
            m_ack = 1'b0;
            if (m_req && rst_n) begin
                if (lat > 0) lat--;
                else begin
                    m_ack = 1'b1;
                    if (!m_we) begin
                        last_rd = m_addr;
                        m_rdata = dat_of(m_addr);
                    end else begin
                        chk(m_wdata == dat_of(last_rd), "R2 data", 32'(m_wdata), 32'(dat_of(last_rd)));
                        q_rd.push_back(last_rd);
                        q_wr.push_back(m_addr);
                    end
                    lat = int'($urandom % 3);
                end
            end
        end
    end

    task automatic wr(input bit u, input logic [2:0] f, input logic [23:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_unit = u; reg_field = f; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input bit u, input logic [2:0] f, output logic [23:0] v);
        @(negedge clk);
        reg_unit = u; reg_field = f;
        #1 v = reg_rdata;
    endtask

    task automatic cfg(input bit u, input logic [7:0] c, input logic [23:0] mar,
                       input logic [7:0] io, input logic [15:0] cnt);
        wr(u, FLD_MAR, mar);
        wr(u, FLD_IOA, 24'(io));
        wr(u, FLD_CNT, 24'(cnt));
        wr(u, FLD_CTL, 24'(c));
        wr(u, FLD_ENA, 24'h80);
    endtask

    task automatic fire(input int code);
        @(negedge clk);
        if (code < 4) tmr_evt[code] = 1'b1;
        else if (code == 4) tx_empty = 1'b1;
        else rx_full = 1'b1;
        @(negedge clk);
        tmr_evt = '0; tx_empty = 1'b0; rx_full = 1'b0;
    endtask

    task automatic check_xfer(input string tag, input logic [7:0] c, input logic [23:0] mar,
                              input logic [7:0] io, input logic [15:0] cnt, input int k);
        logic [23:0] me, ie;
        for (int t = 0; t < 300 && q_wr.size() <= seen; t++) @(negedge clk);
        if (q_wr.size() <= seen) begin
            chk(1'b0, {tag, " no transfer"}, 32'(q_wr.size()), 32'(seen + 1));
            return;
        end
        me = mem_at(c, mar, cnt, k);
        ie = {16'hFFFF, io};
        chk(q_rd[seen] == (c[4] ? ie : me), {tag, " read addr"}, 32'(q_rd[seen]), 32'(c[4] ? ie : me));
        chk(q_wr[seen] == (c[4] ? me : ie), {tag, " write addr"}, 32'(q_wr[seen]), 32'(c[4] ? me : ie));
        seen++;
    endtask

    task automatic quiet(input int n, input string tag);
        int base = q_wr.size();
        repeat (n) @(negedge clk);
        chk(q_wr.size() == base, tag, 32'(q_wr.size()), 32'(base));
    endtask

    task automatic run_mode(input string tag, input bit u, input logic [7:0] c, input logic [23:0] mar,
                            input logic [7:0] io, input logic [15:0] cnt, input int n);
        cfg(u, c, mar, io, cnt);
        for (int k = 0; k < n; k++) begin
            fire(int'(c[2:0]));
            check_xfer(tag, c, mar, io, cnt, k);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL R2 watchdog act=hung exp=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [23:0] v;
        void'($urandom(32'd20250611));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // reset state
        chk(m_req == 1'b0, "R2 reset req", 32'(m_req), 0);
        chk(irq_end == 2'b00, "R12 reset irq", 32'(irq_end), 0);
        rd(0, FLD_ENA, v); chk(v == 0, "R1 reset enable", v, 0);

        // R1 register readback
        wr(0, FLD_IOA, 24'hABC34);
        rd(0, FLD_IOA, v); chk(v == 24'h00FF34, "R1 io readback", v, 24'h00FF34);
        wr(1, FLD_MAR, 24'h123456);
        rd(1, FLD_MAR, v); chk(v == 24'h123456, "R1 mar readback", v, 24'h123456);

        // R3 R4 R5 sequential byte increment, mem to io, interrupt enabled
        run_mode("R4 seq", 0, 8'h08, 24'h001000, 8'h20, 16'd3, 3);
        rd(0, FLD_ENA, v); chk(v == 0, "R5 enable cleared", v, 0);
        chk(irq_end[0] == 1'b1, "R5 irq raised", 32'(irq_end), 1);
        quiet(4, "R12 irq held");
        chk(irq_end[0] == 1'b1, "R12 irq still high", 32'(irq_end), 1);
        wr(0, FLD_ENA, 24'h0);
        chk(irq_end[0] == 1'b0, "R12 irq cleared", 32'(irq_end), 0);

        // R3 R4 word decrement, io to mem, no interrupt
        run_mode("R3 seq word dec", 1, 8'hD4, 24'h002000, 8'h40, 16'd2, 2);
        rd(1, FLD_ENA, v); chk(v == 0, "R5 enable cleared no ie", v, 0);
        chk(irq_end[1] == 1'b0, "R5 no irq without ie", 32'(irq_end), 0);

        // R6 idle mode
        run_mode("R6 idle", 0, 8'h2D, 24'h00A000, 8'h55, 16'd2, 2);
        rd(0, FLD_ENA, v); chk(v == 0, "R6 enable cleared", v, 0);
        chk(irq_end[0] == 1'b1, "R6 irq raised", 32'(irq_end), 1);
        wr(0, FLD_ENA, 24'h0);

        // R7 repeat, low count byte 2
        run_mode("R7 repeat", 1, 8'h23, 24'h003000, 8'h66, 16'h0102, 5);
        rd(1, FLD_ENA, v); chk(v == 24'h80, "R7 stays enabled", v, 24'h80);
        chk(irq_end == 2'b00, "R7 no irq", 32'(irq_end), 0);
        wr(1, FLD_ENA, 24'h0);

        // R7 repeat with zero low byte: 256 then wrap
        run_mode("R7 repeat256", 0, 8'h21, 24'h007000, 8'h01, 16'h0100, 257);
        wr(0, FLD_ENA, 24'h0);

        // R8 trigger select
        cfg(0, 8'h01, 24'h008000, 8'h02, 16'd2);
        fire(0); fire(2); fire(3); fire(4); fire(5);
        quiet(10, "R8 other triggers ignored");
        fire(1);
        check_xfer("R8 selected trigger", 8'h01, 24'h008000, 8'h02, 16'd2, 0);
        wr(0, FLD_ENA, 24'h0);

        // R9 DREQ falling edge on B
        cfg(1, 8'h06, 24'h009000, 8'h03, 16'd5);
        @(negedge clk); dreq_n = 1'b0;
        repeat (15) @(negedge clk);
        check_xfer("R9 edge", 8'h06, 24'h009000, 8'h03, 16'd5, 0);
        quiet(2, "R9 one per edge");
        dreq_n = 1'b1;
        repeat (3) @(negedge clk);
        dreq_n = 1'b0;
        check_xfer("R9 second edge", 8'h06, 24'h009000, 8'h03, 16'd5, 1);
        @(negedge clk); dreq_n = 1'b1;
        wr(1, FLD_ENA, 24'h0);

        // R9 DREQ low level on B
        cfg(1, 8'h07, 24'h00B000, 8'h04, 16'd3);
        @(negedge clk); dreq_n = 1'b0;
        for (int k = 0; k < 3; k++) check_xfer("R9 level", 8'h07, 24'h00B000, 8'h04, 16'd3, k);
        quiet(10, "R9 level stops at count");
        dreq_n = 1'b1;
        rd(1, FLD_ENA, v); chk(v == 0, "R9 level ends", v, 0);

        // R10 full address configuration halts both
        wr(0, FLD_CTL, 24'h06);
        cfg(1, 8'h00, 24'h00C000, 8'h33, 16'd1);
        fire(0);
        quiet(20, "R10 halted");
        wr(0, FLD_CTL, 24'h00);
        fire(0);
        check_xfer("R10 resumes", 8'h00, 24'h00C000, 8'h33, 16'd1, 0);

        // R11 A before B
        cfg(0, 8'h02, 24'h004000, 8'h11, 16'd1);
        cfg(1, 8'h02, 24'h005000, 8'h22, 16'd1);
        fire(2);
        check_xfer("R11 A first", 8'h02, 24'h004000, 8'h11, 16'd1, 0);
        check_xfer("R11 B second", 8'h02, 24'h005000, 8'h22, 16'd1, 0);

        // random sequential runs
        for (int it = 0; it < 30; it++) begin
            bit u;
            logic [7:0] c;
            logic [23:0] mar;
            logic [7:0] io;
            int n;
            u   = 1'($urandom % 2);
            c   = {1'($urandom), 1'($urandom), 1'b0, 1'($urandom), 1'($urandom), 3'($urandom % 6)};
            mar = 24'($urandom);
            io  = 8'($urandom);
            n   = 1 + int'($urandom % 4);
            run_mode("R4 random", u, c, mar, io, 16'(n), n);
            rd(u, FLD_ENA, v); chk(v == 0, "R5 random end", v, 0);
            chk(irq_end[u] == c[3], "R5 random irq", 32'(irq_end[u]), 32'(c[3]));
            wr(u, FLD_ENA, 24'h0);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule